// File: doc/BRIEF.md
# Maskable Interrupt Controller with Selectable Trigger Convention

This block collects up to 32 interrupt lines on their way to a processor core. Each line owns one bit in an enable register and one bit in a pending register. Whenever any line is both pending and enabled, the block raises a single request to the core. Software reaches both registers through a small read/write port. It finds the lines to service by taking the lowest pending, enabled index, which the block computes in hardware.

A build-time parameter fixes how the pending bits behave. In follow mode the pending bits mirror the synchronized inputs, and software writes to them have no effect. In edge mode a rising input sets its bit, and a written 1 clears that bit. In hold mode an asserted input is captured and held after it falls, and a written 0 clears the bit.

Top module: `irqc_top`

## Requirements
- R1: During and after synchronous reset, the enable register and the pending register read as zero, `irq_req` is 0 and `pend_valid` is 0.
- R2: A write with `reg_sel`=0 loads `wr_data` into the enable register. `rd_data` returns the register chosen by `reg_sel` (0 enable, 1 pending), registered one cycle after the selection is presented.
- R3: An input change reaches the pending register on the third rising clock edge, through two synchronizer flops and the pending flop. `irq_req` equals the OR of (pending AND enable), registered one more cycle.
- R4: Follow mode: the pending register equals the synchronized inputs, delayed by one cycle. Writes with `reg_sel`=1 have no effect.
- R5: Edge mode: a 0-to-1 transition of a synchronized input sets its pending bit. A write with `reg_sel`=1 clears every bit written as 1 and leaves bits written as 0 alone. An input that stays high does not set its bit again.
- R6: Hold mode: a synchronized high input sets its pending bit, and the bit stays set after the input falls. A write with `reg_sel`=1 clears every bit written as 0 and leaves bits written as 1 alone.
- R7: When a set event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R8: `pend_valid` is 1 exactly when (pending AND enable) is nonzero. `pend_idx` then gives the lowest set bit position of that vector.
- R9: Clearing an enable bit drops the request for that line. It leaves the line's pending bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Asynchronous interrupt inputs |
| reg_sel | input | 1 | Register select: 0 enable, 1 pending |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data of the selected register |
| irq_req | output | 1 | Interrupt request to the core |
| pend_valid | output | 1 | Some line is pending and enabled |
| pend_idx | output | 5 | Lowest pending, enabled line index |

## Verification
On every cycle, the assertions check the request timing against pending AND enable. They also check the enable write and the one-cycle read path, the lowest-index and valid outputs, and the per-mode set rule: follow mode tracks its input, edge mode sets on a rise, and hold mode never loses a high input even under a clearing write. Some behaviour shows only in the bench scenarios. These are the opposite write-clear polarities of edge and hold mode when the same word is written to both, a bit that stays pending after its input falls, and the absence of a retrigger while an input is held high. The bench also shows that masking leaves the pending bits intact, and that a rise landing in the exact cycle of its clear survives.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        TRIG_FOLLOW = 2'd0,
        TRIG_EDGE   = 2'd1,
        TRIG_HOLD   = 2'd2
    } trig_mode_e;

    typedef enum logic {
        SEL_ENABLE  = 1'b0,
        SEL_PENDING = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/irqc_status.sv
module irqc_status
    import irqc_pkg::*;
#(
    parameter int         WIDTH = 32,
    parameter trig_mode_e MODE  = TRIG_HOLD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sync_in,
    input  logic             wr_pend,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] pend_q
);
    generate
        if (MODE == TRIG_EDGE) begin : g_edge
            logic [WIDTH-1:0] prev_q;
            logic [WIDTH-1:0] rise;
            logic [WIDTH-1:0] clr;
            assign rise = sync_in & ~prev_q;
            assign clr  = wr_pend ? wr_data : '0;
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= '0;
                    pend_q <= '0;
                end else begin
                    prev_q <= sync_in;
                    pend_q <= (pend_q & ~clr) | rise;
                end
            end
        end else if (MODE == TRIG_HOLD) begin : g_hold
            logic [WIDTH-1:0] clr;
            assign clr = wr_pend ? ~wr_data : '0;
            always_ff @(posedge clk) begin
                if (rst) pend_q <= '0;
                else     pend_q <= (pend_q & ~clr) | sync_in;
            end
        end else begin : g_follow
            logic unused_write_bits;
            assign unused_write_bits = wr_pend ^ (^wr_data);
            always_ff @(posedge clk) begin
                if (rst) pend_q <= '0;
                else     pend_q <= sync_in;
            end
        end
    endgenerate
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int WIDTH = 32,
    parameter int IDX_W = 5
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    always_comb begin
        idx   = '0;
        valid = |vec;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int         NUM_LINES = 32,
    parameter trig_mode_e MODE      = TRIG_HOLD,
    localparam int        IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 reg_sel,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] rd_data,
    output logic                 irq_req,
    output logic                 pend_valid,
    output logic [IDX_W-1:0]     pend_idx
);
    reg_sel_e             sel;
    logic [NUM_LINES-1:0] sync_v;
    logic [NUM_LINES-1:0] stat_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] live;
    logic [NUM_LINES-1:0] rd_q;
    logic                 irq_q;
    logic                 wr_pend;

    assign sel     = reg_sel_e'(reg_sel);
    assign wr_pend = wr_en && (sel == SEL_PENDING);

    irqc_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_lines),
        .sync_out (sync_v)
    );

    irqc_status #(.WIDTH(NUM_LINES), .MODE(MODE)) u_status (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_v),
        .wr_pend (wr_pend),
        .wr_data (wr_data),
        .pend_q  (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            rd_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_en && sel == SEL_ENABLE) mask_q <= wr_data;
            rd_q  <= (sel == SEL_PENDING) ? stat_q : mask_q;
            irq_q <= |live;
        end
    end

    assign live = stat_q & mask_q;

    irqc_prio #(.WIDTH(NUM_LINES), .IDX_W(IDX_W)) u_prio (
        .vec   (live),
        .idx   (pend_idx),
        .valid (pend_valid)
    );

    assign rd_data = rd_q;
    assign irq_req = irq_q;
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks
    import irqc_pkg::*;
#(
    parameter int         NUM_LINES = 32,
    parameter trig_mode_e MODE      = TRIG_HOLD,
    localparam int        IDX_W     = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] stat,
    input logic [NUM_LINES-1:0] sync_v,
    input logic                 reg_sel,
    input logic                 wr_en,
    input logic [NUM_LINES-1:0] wr_data,
    input logic [NUM_LINES-1:0] rd_data,
    input logic                 irq_req,
    input logic                 pend_valid,
    input logic [IDX_W-1:0]     pend_idx
);
    logic [NUM_LINES-1:0] below;
    assign below = (NUM_LINES'(1) << pend_idx) - NUM_LINES'(1);

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !reg_sel) |=> (mask == $past(wr_data)));

    // R2
    read_path_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rd_data == $past(reg_sel ? stat : mask)));

    // R3
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_req == $past(|(stat & mask))));

    // R8
    valid_match_chk: assert property (@(posedge clk) disable iff (rst)
        pend_valid == (|(stat & mask)));

    // R8
    idx_set_chk: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> (stat[pend_idx] && mask[pend_idx]));

    // R8
    idx_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> ((stat & mask & below) == '0));

    generate
        if (MODE == TRIG_FOLLOW) begin : g_follow
            // R4
            follow_track_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (stat == $past(sync_v)));
        end else if (MODE == TRIG_EDGE) begin : g_edge
            // R5 R7
            edge_set_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ((($past(sync_v) & ~$past(sync_v, 2)) & ~stat) == '0));
        end else begin : g_hold
            // R6 R7
            hold_set_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ((stat & $past(sync_v)) == $past(sync_v)));
        end
    endgenerate
endmodule

bind irqc_top irqc_checks #(.NUM_LINES(NUM_LINES), .MODE(MODE)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .mask       (mask_q),
    .stat       (stat_q),
    .sync_v     (sync_v),
    .reg_sel    (reg_sel),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .irq_req    (irq_req),
    .pend_valid (pend_valid),
    .pend_idx   (pend_idx)
);

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;
    import irqc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_lines = '0;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;

    logic [31:0] rd_h, rd_e, rd_f;
    logic        irq_h, irq_e, irq_f;
    logic        val_h, val_e, val_f;
    logic [4:0]  idx_h, idx_e, idx_f;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irqc_top u_irqc_top (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_h), .irq_req(irq_h),
        .pend_valid(val_h), .pend_idx(idx_h));

    irqc_top #(.MODE(TRIG_EDGE)) u_irqc_top_edge (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_e), .irq_req(irq_e),
        .pend_valid(val_e), .pend_idx(idx_e));

    irqc_top #(.MODE(TRIG_FOLLOW)) u_irqc_top_follow (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_f), .irq_req(irq_f),
        .pend_valid(val_f), .pend_idx(idx_f));

    // {pattern, valid, index} for the follow-mode instance, all lines enabled
    localparam logic [37:0] VECS [6] = '{
        {32'h0000_0000, 1'b0, 5'd0},
        {32'h0000_0001, 1'b1, 5'd0},
        {32'h8000_0000, 1'b1, 5'd31},
        {32'h00F0_0000, 1'b1, 5'd20},
        {32'hFFFF_FFFF, 1'b1, 5'd0},
        {32'h0001_0100, 1'b1, 5'd8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        reg_sel = sel;
        wr_data = data;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic sel);
        reg_sel = sel;
        wr_en   = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_all(input string req, input logic sel,
                          input logic [31:0] eh, input logic [31:0] ee, input logic [31:0] ef);
        rd(sel);
        chk({req, " hold"},   rd_h, eh);
        chk({req, " edge"},   rd_e, ee);
        chk({req, " follow"}, rd_f, ef);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 irq in reset", {31'd0, irq_h | irq_e | irq_f}, 32'd0);
        chk("R1 rd in reset", rd_h | rd_e | rd_f, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        rd_all("R1 enable after reset", 1'b0, 32'd0, 32'd0, 32'd0);
        rd_all("R1 pending after reset", 1'b1, 32'd0, 32'd0, 32'd0);
        chk("R1 valid after reset", {31'd0, val_h | val_e | val_f}, 32'd0);

        // R2: enable write and readback
        wr(1'b0, 32'hFFFF_FFFF);
        rd_all("R2 enable readback", 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R8 R3 R4: lowest-index table on the follow instance
        for (int v = 0; v < 6; v++) begin
            irq_lines = VECS[v][37:6];
            settle();
            chk("R8 pend_valid", {31'd0, val_f}, {31'd0, VECS[v][5]});
            if (VECS[v][5]) chk("R8 pend_idx", {27'd0, idx_f}, {27'd0, VECS[v][4:0]});
            chk("R3 irq_req", {31'd0, irq_f}, {31'd0, VECS[v][5]});
        end
        irq_lines = '0;
        settle();
        rd_all("R4 R5 R6 after table", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);

        // R5 R6: opposite clear polarities, same written word
        wr(1'b1, 32'hFFFF_FFFE);
        rd_all("R5 R6 clear polarity", 1'b1, 32'hFFFF_FFFE, 32'h0000_0001, 32'h0);
        wr(1'b1, 32'h0000_0000);
        rd_all("R5 R6 write zeros", 1'b1, 32'h0, 32'h0000_0001, 32'h0);
        wr(1'b1, 32'hFFFF_FFFF);
        rd_all("R5 R6 write ones", 1'b1, 32'h0, 32'h0, 32'h0);

        // R3: input to request latency of four edges
        irq_lines[5] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 irq not before 4th edge", {31'd0, irq_f}, 32'd0);
        @(negedge clk);
        chk("R3 irq at 4th edge", {31'd0, irq_f & irq_e & irq_h}, 32'd1);
        chk("R8 idx line5", {27'd0, idx_h}, 32'd5);
        // R4: follow-mode writes ignored; R7 hold keeps a high input
        wr(1'b1, 32'h0);
        rd_all("R4 R7 write zeros while high", 1'b1, 32'h20, 32'h20, 32'h20);

        // R9: masking stops request but keeps pending
        wr(1'b0, 32'hFFFF_FFDF);
        @(negedge clk);
        chk("R9 irq masked", {31'd0, irq_h | irq_e | irq_f}, 32'd0);
        chk("R9 valid masked", {31'd0, val_h | val_e | val_f}, 32'd0);
        rd_all("R9 pending kept", 1'b1, 32'h20, 32'h20, 32'h20);
        wr(1'b0, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R9 irq unmasked", {31'd0, irq_h & irq_e & irq_f}, 32'd1);

        // R6: hold keeps bit after input falls; follow drops it
        irq_lines[5] = 1'b0;
        settle();
        rd_all("R6 held after fall", 1'b1, 32'h20, 32'h20, 32'h0);
        chk("R4 follow irq dropped", {31'd0, irq_f}, 32'd0);
        chk("R6 hold irq kept", {31'd0, irq_h}, 32'd1);

        // R5: no retrigger while held high
        irq_lines[7] = 1'b1;
        settle();
        rd_all("R5 R6 line7 up", 1'b1, 32'hA0, 32'hA0, 32'h80);
        wr(1'b1, 32'h80);
        settle();
        rd_all("R5 no retrigger", 1'b1, 32'h80, 32'h20, 32'h80);
        wr(1'b1, 32'hFFFF_FF7F);
        rd_all("R7 hold clear while high", 1'b1, 32'h80, 32'h0, 32'h80);
        irq_lines[7] = 1'b0;
        settle();
        wr(1'b1, 32'h0);
        rd_all("R6 hold cleared", 1'b1, 32'h0, 32'h0, 32'h0);

        // R7: rise lands in the same cycle as a clearing write
        irq_lines[9] = 1'b1;
        repeat (2) @(negedge clk);
        wr(1'b1, 32'h200);
        settle();
        rd_all("R7 set wins", 1'b1, 32'h200, 32'h200, 32'h200);

        // R1: mid-run reset
        irq_lines = '0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_all("R1 enable after rerst", 1'b0, 32'h0, 32'h0, 32'h0);
        rd_all("R1 pending after rerst", 1'b1, 32'h0, 32'h0, 32'h0);
        chk("R1 irq after rerst", {31'd0, irq_h | irq_e | irq_f}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule